// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block watches an asynchronous serial line and builds one character at a time from it. A 16x oversampling enable paces it. A falling edge on the idle line may be a start bit. The block checks the line again at the middle of that start bit, so a short low pulse is thrown away. After that it takes every data bit, the optional parity bit and a single stop bit at the middle of each bit period. The least significant bit comes first on the line.

When the stop bit has been sampled, the block writes the finished byte to a downstream receive FIFO in one clock cycle. The framing and parity flags for that character go out in the same cycle. Characters shorter than eight bits are right-justified. When the received parity bit fits, it sits directly above the data bits, and every position above that reads as 1.

The character length, parity enable and parity sense are sampled when a start bit is recognised. Software can therefore change them between characters without corrupting a character already on the line.

Top module: `serial_char_assembler`

## Requirements
- R1: `cfg_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The first data bit on the line lands in `wr_data[0]`.
- R2: Every bit of `wr_data` above the data bits, and above the parity bit when that bit is stored, is 1.
- R3: With parity enabled and fewer than 8 data bits, the received parity bit appears in `wr_data` at bit index equal to the data length. With 8 data bits and parity, `wr_data` holds only the 8 data bits.
- R4: With `cfg_par_even` = 1, the data bits and parity bit together must hold an even number of ones. With `cfg_par_even` = 0 they must hold an odd number. Otherwise `wr_par_err` is 1 alongside that character.
- R5: With `cfg_par_en` = 0, no parity bit is expected and `wr_par_err` stays 0.
- R6: Exactly one stop bit is sampled. If it reads 0, `wr_frame_err` is 1 in the same cycle as the `wr_en` strobe for that character.
- R7: A low pulse that has ended by the middle of the start bit produces no character.
- R8: `wr_en` is a single-cycle pulse. It does not come before the stop bit's midpoint, and both error flags are 0 whenever `wr_en` is 0.
- R9: A new start edge is accepted right after a stop bit, including straight after a frame that had a framing error, once the line has gone high again.
- R10: During and after synchronous reset, `wr_en`, `wr_data`, `wr_frame_err` and `wr_par_err` are 0 until the first character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Expect a parity bit after the data |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| wr_data | output | 8 | Assembled, padded character |
| wr_en | output | 1 | Single-cycle FIFO write strobe |
| wr_frame_err | output | 1 | Stop bit read as 0 for this character |
| wr_par_err | output | 1 | Parity mismatch for this character |

## Verification
The line passes through a two-stage synchroniser and is then seen on the next tick. The start bit is confirmed 8 ticks after that. Each later bit is sampled 16 ticks after the previous one, and the strobe is registered one clock after the tick that samples the stop bit. The character therefore appears about half a bit period into the stop bit. The bench checks that nothing has been written while the stop bit is still being driven onto the line. It reads the results only after the full stop bit plus any gap, and it samples outputs on the falling clock edge. Back-to-back frames and the recovery after a glitch or a framing error are checked by counting strobes between those points.

// File: rtl/scha_pkg.sv
package scha_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } scha_state_e;

  // number of data bits for a 2-bit length code (0..3 -> 5..8)
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction
endpackage

// File: rtl/scha_line_sync.sv
module scha_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= rxd;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], rxd};
      end
    end
  endgenerate

  assign line = sr[STAGES-1];

  // line value seen on the previous tick
  always_ff @(posedge clk) begin
    if (rst)       prev <= 1'b1;
    else if (tick) prev <= line;
  end

  assign fall = tick & prev & ~line;
endmodule

// File: rtl/scha_frame_ctl.sv
module scha_frame_ctl
  import scha_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line,
  input  logic              fall,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  output logic              done,
  output logic [DATA_W:0]   shreg,
  output logic [3:0]        total,
  output logic              frame_err,
  output logic              par_err,
  output logic [1:0]        len_q,
  output logic              pen_q
);
  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;

  scha_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       bit_idx;
  logic             even_q;
  logic             acc;

  assign total = char_bits(len_q) + {3'b000, pen_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      acc       <= 1'b0;
      len_q     <= '0;
      pen_q     <= 1'b0;
      even_q    <= 1'b0;
      done      <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fall) begin
            state  <= ST_START;
            cnt    <= '0;
            len_q  <= cfg_len;
            pen_q  <= cfg_par_en;
            even_q <= cfg_par_even;
          end
        end
        ST_START: begin
          if (tick) begin
            if (cnt == CNT_W'(HALF - 1)) begin
              cnt <= '0;
              if (!line) begin
                state   <= ST_BITS;
                bit_idx <= '0;
                shreg   <= '0;
                acc     <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_BITS: begin
          if (tick) begin
            if (cnt == CNT_W'(OSR - 1)) begin
              cnt     <= '0;
              shreg   <= {line, shreg[DATA_W:1]};
              acc     <= acc ^ line;
              bit_idx <= bit_idx + 4'd1;
              if (bit_idx == total - 4'd1) state <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (cnt == CNT_W'(OSR - 1)) begin
              cnt       <= '0;
              done      <= 1'b1;
              frame_err <= ~line;
              par_err   <= pen_q & (acc ^ ~even_q);
              state     <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scha_byte_pack.sv
module scha_byte_pack #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W:0]   shreg,
  input  logic [3:0]        total,
  input  logic              frame_err,
  input  logic              par_err,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              wr_frame_err,
  output logic              wr_par_err
);
  localparam int SH_W = DATA_W + 1;

  logic [DATA_W:0]   aligned;
  logic [3:0]        kept;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] packed_byte;

  always_comb begin
    aligned     = shreg >> (4'(SH_W) - total);
    kept        = (total > 4'(DATA_W)) ? 4'(DATA_W) : total;
    mask        = ~({DATA_W{1'b1}} << kept);
    packed_byte = (aligned[DATA_W-1:0] & mask) | ~mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_data      <= '0;
      wr_en        <= 1'b0;
      wr_frame_err <= 1'b0;
      wr_par_err   <= 1'b0;
    end else begin
      wr_en        <= done;
      wr_frame_err <= done & frame_err;
      wr_par_err   <= done & par_err;
      if (done) wr_data <= packed_byte;
    end
  end
endmodule

// File: rtl/serial_char_assembler.sv
module serial_char_assembler #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              wr_frame_err,
  output logic              wr_par_err
);
  logic            line;
  logic            fall;
  logic            done;
  logic [DATA_W:0] shreg;
  logic [3:0]      total;
  logic            frame_err;
  logic            par_err;
  logic [1:0]      len_q;
  logic            pen_q;

  scha_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .rxd  (rxd),
    .line (line),
    .fall (fall)
  );

  scha_frame_ctl #(.OSR(OSR), .DATA_W(DATA_W)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .line         (line),
    .fall         (fall),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_even (cfg_par_even),
    .done         (done),
    .shreg        (shreg),
    .total        (total),
    .frame_err    (frame_err),
    .par_err      (par_err),
    .len_q        (len_q),
    .pen_q        (pen_q)
  );

  scha_byte_pack #(.DATA_W(DATA_W)) u_pack (
    .clk          (clk),
    .rst          (rst),
    .done         (done),
    .shreg        (shreg),
    .total        (total),
    .frame_err    (frame_err),
    .par_err      (par_err),
    .wr_data      (wr_data),
    .wr_en        (wr_en),
    .wr_frame_err (wr_frame_err),
    .wr_par_err   (wr_par_err)
  );
endmodule

// File: rtl/scha_checker.sv
module scha_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] wr_data,
  input logic       wr_en,
  input logic       wr_frame_err,
  input logic       wr_par_err,
  input logic [1:0] len_q,
  input logic       pen_q
);
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R8
  ferr_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_frame_err |-> wr_en);

  // R8
  perr_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_par_err |-> wr_en);

  // R2
  pad_five_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && len_q == 2'd0 && !pen_q) |-> (wr_data[7:5] == 3'b111));

  // R3
  pad_five_par_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && len_q == 2'd0 && pen_q) |-> (wr_data[7:6] == 2'b11));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!wr_en && !wr_frame_err && !wr_par_err));
endmodule

bind serial_char_assembler scha_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_data      (wr_data),
  .wr_en        (wr_en),
  .wr_frame_err (wr_frame_err),
  .wr_par_err   (wr_par_err),
  .len_q        (len_q),
  .pen_q        (pen_q)
);

// File: tb/sim_serial_char_assembler.sv
`timescale 1ns/1ps
module sim_serial_char_assembler;
  localparam int BIT_CLK = 64; // 16 ticks, one tick every 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic [7:0] wr_data;
  logic       wr_en;
  logic       wr_frame_err;
  logic       wr_par_err;

  int errors = 0;
  int checks = 0;
  int rx_count = 0;
  logic [7:0] last_data = 8'h00, prev_data = 8'h00;
  logic last_fe = 1'b0, last_pe = 1'b0;
  logic [1:0] div = 2'd0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  serial_char_assembler u0 (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .wr_data(wr_data), .wr_en(wr_en),
    .wr_frame_err(wr_frame_err), .wr_par_err(wr_par_err)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      rx_count  = rx_count + 1;
      prev_data = last_data;
      last_data = wr_data;
      last_fe   = wr_frame_err;
      last_pe   = wr_par_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bits(input int k);
    repeat (k * BIT_CLK) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] d, input int n,
                                          input bit pen, input bit pbit);
    logic [7:0] b = 8'hFF;
    for (int i = 0; i < n; i++) b[i] = d[i];
    if (pen && n < 8) b[n] = pbit;
    return b;
  endfunction

  function automatic bit good_par(input logic [7:0] d, input int n, input bit even);
    bit ones = 1'b0;
    for (int i = 0; i < n; i++) ones ^= d[i];
    return even ? ones : ~ones;
  endfunction

  // drives one frame; returns the parity bit sent
  task automatic send_frame(input logic [7:0] d, input int n, input bit pen,
                            input bit even, input bit bad_par, input bit stopv,
                            input int gap, input bit early_chk, output bit pbit);
    int c0 = rx_count;
    pbit = good_par(d, n, even) ^ bad_par;
    rxd = 1'b0; hold_bits(1);
    for (int i = 0; i < n; i++) begin rxd = d[i]; hold_bits(1); end
    if (pen) begin rxd = pbit; hold_bits(1); end
    if (early_chk) chk(rx_count == c0, "R8 no early strobe", rx_count, c0);
    rxd = stopv; hold_bits(1);
    rxd = 1'b1; hold_bits(gap);
  endtask

  task automatic frame_test(input logic [7:0] d, input int n, input bit pen,
                            input bit even, input bit bad_par, input bit stopv,
                            input string req);
    int c0 = rx_count;
    bit pbit;
    logic [7:0] e;
    cfg_len = 2'(n - 5); cfg_par_en = pen; cfg_par_even = even;
    send_frame(d, n, pen, even, bad_par, stopv, 1, 1'b1, pbit);
    e = exp_byte(d, n, pen, pbit);
    chk(rx_count == c0 + 1, {req, " one strobe"}, rx_count - c0, 1);
    chk(last_data == e, {req, " data"}, last_data, e);
    chk(last_fe == !stopv, "R6 framing flag", last_fe, !stopv);
    chk(last_pe == (pen && bad_par), "R4/R5 parity flag", last_pe, pen && bad_par);
  endtask

  task automatic t_reset;
    chk(wr_en == 1'b0, "R10 strobe", wr_en, 0);
    chk(wr_data == 8'h00, "R10 data", wr_data, 0);
    chk(wr_frame_err == 1'b0 && wr_par_err == 1'b0, "R10 flags",
        {wr_frame_err, wr_par_err}, 0);
  endtask

  task automatic t_lengths;
    frame_test(8'hA5, 8, 0, 0, 0, 1, "R1 len8");
    frame_test(8'h3C, 7, 0, 0, 0, 1, "R1 len7 R2");
    frame_test(8'h15, 6, 0, 0, 0, 1, "R1 len6 R2");
    frame_test(8'h0A, 5, 0, 0, 0, 1, "R1 len5 R2");
    frame_test(8'h00, 5, 0, 1, 0, 1, "R2 zeros R5");
  endtask

  task automatic t_parity;
    frame_test(8'h55, 7, 1, 1, 0, 1, "R3 len7 even");
    frame_test(8'h13, 5, 1, 0, 0, 1, "R3 len5 odd");
    frame_test(8'h2E, 6, 1, 1, 1, 1, "R4 len6 bad even");
    frame_test(8'h01, 7, 1, 0, 1, 1, "R4 len7 bad odd");
    frame_test(8'hC3, 8, 1, 1, 0, 1, "R3 len8 no room");
    frame_test(8'h7E, 8, 1, 0, 1, 1, "R4 len8 bad odd");
  endtask

  task automatic t_framing;
    frame_test(8'h96, 8, 0, 0, 0, 0, "R6 stop low");
    frame_test(8'h5A, 8, 0, 0, 0, 1, "R9 after framing error");
  endtask

  task automatic t_glitch;
    int c0 = rx_count;
    cfg_len = 2'd3; cfg_par_en = 1'b0;
    rxd = 1'b0; repeat (12) @(negedge clk);
    rxd = 1'b1; hold_bits(12);
    chk(rx_count == c0, "R7 glitch ignored", rx_count, c0);
    frame_test(8'h81, 8, 0, 0, 0, 1, "R7 recovery");
  endtask

  task automatic t_back2back;
    int c0 = rx_count;
    bit p;
    cfg_len = 2'd3; cfg_par_en = 1'b0;
    send_frame(8'h11, 8, 0, 0, 0, 1, 0, 1'b1, p);
    send_frame(8'hEE, 8, 0, 0, 0, 1, 1, 1'b0, p);
    chk(rx_count == c0 + 2, "R9 two strobes", rx_count - c0, 2);
    chk(prev_data == 8'h11, "R9 first byte", prev_data, 8'h11);
    chk(last_data == 8'hEE, "R9 second byte", last_data, 8'hEE);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hold_bits(1);
    t_reset();
    t_lengths();
    t_parity();
    t_framing();
    t_glitch();
    t_back2back();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule